// File: doc/BRIEF.md
# Nine-Bit Word Packer

This block lets a master that can only shift whole bytes drive a display link whose words are nine bits wide. Each input word carries a data/command flag in its ninth bit and a payload byte below it. The block collects eight such words and turns their 72 bits into nine consecutive bytes on a byte stream. A byte-wide serializer downstream then produces a bitstream identical to a native nine-bit transfer.

A transfer begins with a one-cycle start request that carries the transfer length in words. A length that is zero, or that is not a multiple of eight, is refused with a one-cycle error pulse, and no word or byte moves. A legal length is processed group by group. Input words and output bytes each use a valid/ready handshake. The input is closed while a finished group is draining. A one-cycle done pulse marks the acceptance of the final byte.

Top module: `nine_bit_packer`

## Requirements
- R1: Bit 8 of `in_word` is the data/command flag and bits 7:0 are the payload; bits 15:9 have no effect on any output byte.
- R2: Within a group, words appear in arrival order, each as its flag followed by its payload from bit 7 down to bit 0, and every output byte carries the earliest of its eight bits in bit 7.
- R3: Each group of eight accepted words yields exactly nine output bytes, with no fill bits, so a transfer of N words yields 9*N/8 bytes.
- R4: A start with a length of zero or a length not divisible by eight raises `err` for exactly the following cycle, leaves the block idle, and produces no input acceptance and no output byte.
- R5: A start with a legal length raises `in_ready` in the following cycle, and each cycle with `in_valid` and `in_ready` high accepts one word.
- R6: `in_ready` stays low while the nine bytes of a completed group drain, `out_valid` is high only during that drain, and the two are never high together.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_byte` holds its value into the next cycle.
- R8: `done` is high for exactly the one cycle after the final byte of the final group is accepted, and the block is then idle.
- R9: A start request that arrives while a transfer is in progress is ignored: it produces no error and does not alter the byte stream.
- R10: A synchronous reset discards any partial group and leaves `in_ready`, `out_valid`, `err` and `done` low. The next transfer starts from an empty group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to begin a transfer |
| len_words | input | 16 | Transfer length in words, sampled with `start` |
| in_valid | input | 1 | Input word is present |
| in_word | input | 16 | Input word; flag in bit 8, payload in bits 7:0 |
| in_ready | output | 1 | Block accepts an input word this cycle |
| out_ready | input | 1 | Downstream accepts the output byte this cycle |
| out_valid | output | 1 | Output byte is present |
| out_byte | output | 8 | Packed output byte |
| err | output | 1 | One-cycle pulse: start refused for illegal length |
| done | output | 1 | One-cycle pulse: last byte of the transfer accepted |

## Verification
The assertions check the handshake rules on every cycle. They confirm that input and output are never open together, that a stalled byte holds steady, that error and done pulses leave the block idle and do not repeat, and that reset clears the outputs. Some properties depend on the data: the bit order across word and byte boundaries, the fact that upper input bits are ignored, the byte count of multi-group transfers, and the way starts are refused while busy. Only the bench's scenarios can show these, because they compare every accepted byte against a behavioural model under random stalls on both sides.

// File: rtl/nine_bit_packer_pkg.sv
package nine_bit_packer_pkg;

    typedef enum logic [1:0] {
        PK_IDLE  = 2'd0,
        PK_FILL  = 2'd1,
        PK_DRAIN = 2'd2
    } pk_state_e;

endpackage

// File: rtl/nsp_len_check.sv
module nsp_len_check #(
    parameter int LEN_W       = 16,
    parameter int GROUP_WORDS = 8
) (
    input  logic [LEN_W-1:0] len_words,
    output logic             legal,
    output logic [LEN_W-1:0] groups
);
    localparam int GLOG = $clog2(GROUP_WORDS);

    // group size is a power of two: legality is a zero remainder and a nonzero length
    always_comb begin
        legal  = (len_words != '0) && (len_words[GLOG-1:0] == '0);
        groups = len_words >> GLOG;
    end
endmodule

// File: rtl/nsp_accum.sv
module nsp_accum #(
    parameter int SYM_W       = 9,
    parameter int GROUP_WORDS = 8,
    parameter int BYTE_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push_sym,
    input  logic [SYM_W-1:0]  sym,
    input  logic              pop_byte,
    output logic [BYTE_W-1:0] head
);
    localparam int ACC_W = SYM_W * GROUP_WORDS;

    logic [ACC_W-1:0] acc_d, acc_q;

    // symbols enter at the bottom, bytes leave from the top
    always_comb begin
        acc_d = acc_q;
        if (clear) begin
            acc_d = '0;
        end else if (push_sym) begin
            acc_d = {acc_q[ACC_W-SYM_W-1:0], sym};
        end else if (pop_byte) begin
            acc_d = {acc_q[ACC_W-BYTE_W-1:0], {BYTE_W{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) acc_q <= '0;
        else     acc_q <= acc_d;
    end

    assign head = acc_q[ACC_W-1 -: BYTE_W];
endmodule

// File: rtl/nsp_ctrl.sv
module nsp_ctrl
    import nine_bit_packer_pkg::*;
#(
    parameter int LEN_W           = 16,
    parameter int GROUP_WORDS     = 8,
    parameter int BYTES_PER_GROUP = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             legal,
    input  logic [LEN_W-1:0] groups,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             out_valid,
    output logic             clear,
    output logic             push_sym,
    output logic             pop_byte,
    output logic             err,
    output logic             done
);
    localparam int WCW = $clog2(GROUP_WORDS);
    localparam int BCW = $clog2(BYTES_PER_GROUP);

    typedef struct packed {
        pk_state_e        state;
        logic [WCW-1:0]   word_cnt;
        logic [BCW-1:0]   byte_cnt;
        logic [LEN_W-1:0] grp_left;
        logic             err;
        logic             done;
    } ctrl_t;

    ctrl_t q, d;

    always_comb begin
        d        = q;
        d.err    = 1'b0;
        d.done   = 1'b0;
        clear    = 1'b0;
        push_sym = 1'b0;
        pop_byte = 1'b0;
        unique case (q.state)
            PK_IDLE: begin
                if (start) begin
                    if (legal) begin
                        d.state    = PK_FILL;
                        d.grp_left = groups;
                        d.word_cnt = '0;
                        clear      = 1'b1;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            PK_FILL: begin
                if (in_valid) begin
                    push_sym = 1'b1;
                    if (q.word_cnt == WCW'(GROUP_WORDS - 1)) begin
                        d.state    = PK_DRAIN;
                        d.byte_cnt = '0;
                    end else begin
                        d.word_cnt = q.word_cnt + WCW'(1);
                    end
                end
            end
            PK_DRAIN: begin
                if (out_ready) begin
                    pop_byte = 1'b1;
                    if (q.byte_cnt == BCW'(BYTES_PER_GROUP - 1)) begin
                        if (q.grp_left == LEN_W'(1)) begin
                            d.state = PK_IDLE;
                            d.done  = 1'b1;
                        end else begin
                            d.grp_left = q.grp_left - LEN_W'(1);
                            d.state    = PK_FILL;
                            d.word_cnt = '0;
                        end
                    end else begin
                        d.byte_cnt = q.byte_cnt + BCW'(1);
                    end
                end
            end
            default: d.state = PK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.state    <= PK_IDLE;
            q.word_cnt <= '0;
            q.byte_cnt <= '0;
            q.grp_left <= '0;
            q.err      <= 1'b0;
            q.done     <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign in_ready  = (q.state == PK_FILL);
    assign out_valid = (q.state == PK_DRAIN);
    assign err       = q.err;
    assign done      = q.done;
endmodule

// File: rtl/nine_bit_packer.sv
module nine_bit_packer #(
    parameter int IN_W        = 16,
    parameter int SYM_W       = 9,
    parameter int BYTE_W      = 8,
    parameter int GROUP_WORDS = 8,
    parameter int LEN_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  len_words,
    input  logic              in_valid,
    input  logic [IN_W-1:0]   in_word,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_byte,
    output logic              err,
    output logic              done
);
    localparam int ACC_W           = SYM_W * GROUP_WORDS;
    localparam int BYTES_PER_GROUP = ACC_W / BYTE_W;

    logic             legal;
    logic [LEN_W-1:0] groups;
    logic             clear, push_sym, pop_byte;
    logic             unused_upper;

    assign unused_upper = ^in_word[IN_W-1:SYM_W];

    nsp_len_check #(
        .LEN_W(LEN_W), .GROUP_WORDS(GROUP_WORDS)
    ) u_len (
        .len_words(len_words), .legal(legal), .groups(groups)
    );

    nsp_ctrl #(
        .LEN_W(LEN_W), .GROUP_WORDS(GROUP_WORDS), .BYTES_PER_GROUP(BYTES_PER_GROUP)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .legal(legal), .groups(groups),
        .in_valid(in_valid), .out_ready(out_ready),
        .in_ready(in_ready), .out_valid(out_valid),
        .clear(clear), .push_sym(push_sym), .pop_byte(pop_byte),
        .err(err), .done(done)
    );

    nsp_accum #(
        .SYM_W(SYM_W), .GROUP_WORDS(GROUP_WORDS), .BYTE_W(BYTE_W)
    ) u_acc (
        .clk(clk), .rst(rst), .clear(clear), .push_sym(push_sym),
        .sym(in_word[SYM_W-1:0]), .pop_byte(pop_byte), .head(out_byte)
    );
endmodule

// File: rtl/nine_bit_packer_chk.sv
module nine_bit_packer_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [BYTE_W-1:0] out_byte,
    input logic              err,
    input logic              done
);
    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(in_ready && out_valid)); // R6
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst) (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R7
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst) err |-> (!in_ready && !out_valid)); // R4
    AST_ERR_AFTER_START: assert property (@(posedge clk) disable iff (rst) err |-> $past(start)); // R4
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> (!in_ready && !out_valid)); // R8
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!in_ready && !out_valid && !err && !done)); // R10
endmodule

bind nine_bit_packer nine_bit_packer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk(clk), .rst(rst), .start(start), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .err(err), .done(done)
);

// File: tb/nine_bit_packer_test.sv
module nine_bit_packer_test;
    logic        clk = 1'b0;
    logic        rst, start, in_valid, out_ready;
    logic [15:0] len_words, in_word;
    logic        in_ready, out_valid, err, done;
    logic [7:0]  out_byte;

    always #10 clk = ~clk;

    nine_bit_packer uut (
        .clk(clk), .rst(rst), .start(start), .len_words(len_words),
        .in_valid(in_valid), .in_word(in_word), .in_ready(in_ready),
        .out_ready(out_ready), .out_valid(out_valid), .out_byte(out_byte),
        .err(err), .done(done)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit rand_en = 0;

    // behavioural reference model
    int         m_state = 0, m_words = 0, m_bytes = 0, m_groups = 0;
    bit         m_err = 0, m_done = 0;
    int         done_cnt = 0;
    logic [8:0] m_grp [8];
    logic [7:0] expq [$];
    logic [7:0] rx_q [$];
    logic [8:0] feed_q [$];
    logic [7:0] cur_byte = 8'h00;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic pack_group();
        bit bits [72];
        for (int i = 0; i < 8; i++)
            for (int k = 8; k >= 0; k--)
                bits[i*9 + (8-k)] = m_grp[i][k];
        for (int j = 0; j < 9; j++) begin
            logic [7:0] v;
            for (int t = 0; t < 8; t++) v[7-t] = bits[j*8 + t];
            expq.push_back(v);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            chk(0, "watchdog", cyc, 0);
            summary();
        end
        if (rst) begin
            m_state = 0; m_words = 0; m_bytes = 0; m_groups = 0;
            m_err = 0; m_done = 0;
            expq.delete();
        end else begin
            m_err = 0; m_done = 0;
            case (m_state)
                0: if (start) begin
                    if (len_words != 0 && len_words % 8 == 0) begin
                        m_state = 1; m_groups = len_words / 8; m_words = 0;
                    end else m_err = 1;
                end
                1: if (in_valid) begin
                    m_grp[m_words] = in_word[8:0];
                    if (feed_q.size() > 0) void'(feed_q.pop_front());
                    if (m_words == 7) begin
                        pack_group(); m_state = 2; m_bytes = 0;
                    end else m_words++;
                end
                default: if (out_ready) begin
                    if (expq.size() > 0) void'(expq.pop_front());
                    rx_q.push_back(cur_byte);
                    if (m_bytes == 8) begin
                        if (m_groups == 1) begin
                            m_state = 0; m_done = 1; done_cnt++;
                        end else begin
                            m_groups--; m_state = 1; m_words = 0;
                        end
                    end else m_bytes++;
                end
            endcase
        end
    end

    // stimulus for the streaming sides
    always @(negedge clk) begin
        if (feed_q.size() > 0 && (!rand_en || $urandom % 4 != 0)) begin
            in_valid <= 1'b1;
            in_word  <= {7'($urandom), feed_q[0]};
        end else begin
            in_valid <= 1'b0;
            in_word  <= 16'($urandom);
        end
        out_ready <= rand_en ? ($urandom % 3 != 0) : 1'b1;
    end

    // per-cycle comparison with the model
    always @(negedge clk) begin
        cur_byte = out_byte;
        if (!rst && cyc > 0) begin
            chk(in_ready == (m_state == 1), "R6 in_ready", in_ready, m_state == 1);
            chk(out_valid == (m_state == 2), "R6 out_valid", out_valid, m_state == 2);
            if (m_state == 2 && expq.size() > 0)
                chk(out_byte == expq[0], "R2 out_byte", out_byte, expq[0]);
            chk(err == m_err, "R4 err", err, m_err);
            chk(done == m_done, "R8 done", done, m_done);
        end
    end

    task automatic run(input int n, input bit poke);
        int d0 = done_cnt;
        rx_q.delete();
        @(negedge clk); start = 1; len_words = 16'(n);
        @(negedge clk); start = 0;
        chk(in_ready == 1, "R5 ready after start", in_ready, 1);
        if (poke) begin
            repeat (2) @(negedge clk);
            start = 1; len_words = 16'd3;
            @(negedge clk); start = 0;
            chk(err == 0, "R9 start while busy", err, 0);
        end
        for (int c = 0; c < 5000 && done_cnt == d0; c++) @(negedge clk);
        chk(done_cnt == d0 + 1, "R8 transfer completes", done_cnt, d0 + 1);
        chk(rx_q.size() == 9 * (n / 8), "R3 byte count", rx_q.size(), 9 * (n / 8));
        @(negedge clk);
    endtask

    task automatic refuse(input int n);
        @(negedge clk); start = 1; len_words = 16'(n);
        @(negedge clk); start = 0;
        chk(err == 1, "R4 illegal length", err, 1);
        chk(in_ready == 0, "R4 no acceptance", in_ready, 0);
        @(negedge clk);
        chk(err == 0, "R4 single pulse", err, 0);
    endtask

    initial begin
        rst = 1; start = 0; len_words = 0;
        repeat (3) @(negedge clk);
        chk(!in_ready && !out_valid && !err && !done, "R10 reset state",
            {in_ready, out_valid, err, done}, 0);
        rst = 0;

        // flags only: each flag lands one bit further right in successive bytes
        for (int i = 0; i < 8; i++) feed_q.push_back(9'h100);
        run(8, 0);
        for (int k = 0; k < 9; k++)
            chk(rx_q.size() > k && rx_q[k] == ((k < 8) ? (8'h80 >> k) : 8'h00),
                "R1 flag placement", (rx_q.size() > k) ? rx_q[k] : 0,
                (k < 8) ? (8'h80 >> k) : 0);

        // payload order across a byte boundary
        feed_q.push_back(9'h0A5);
        for (int i = 1; i < 8; i++) feed_q.push_back(9'h1FF);
        run(8, 0);
        chk(rx_q.size() > 1 && rx_q[0] == 8'h52, "R2 first byte", rx_q[0], 8'h52);
        chk(rx_q.size() > 1 && rx_q[1] == 8'hFF, "R2 second byte", rx_q[1], 8'hFF);

        refuse(0);
        refuse(5);
        refuse(12);

        // random data, random stalls, three groups, start poked while busy
        rand_en = 1;
        for (int i = 0; i < 24; i++) feed_q.push_back(9'($urandom));
        run(24, 1);

        // reset in the middle of a group
        @(negedge clk); start = 1; len_words = 16'd8;
        for (int i = 0; i < 8; i++) feed_q.push_back(9'h0F0);
        @(negedge clk); start = 0;
        repeat (4) @(negedge clk);
        rst = 1; feed_q.delete();
        @(negedge clk);
        @(negedge clk);
        chk(!in_ready && !out_valid && !err && !done, "R10 reset mid-group",
            {in_ready, out_valid, err, done}, 0);
        rst = 0;
        rand_en = 0;
        for (int i = 0; i < 8; i++) feed_q.push_back(9'h100);
        run(8, 0);
        chk(rx_q.size() > 0 && rx_q[0] == 8'h80, "R10 fresh group", rx_q[0], 8'h80);

        repeat (3) @(negedge clk);
        summary();
    end
endmodule